// File: doc/BRIEF.md
# MDIO Management Access Controller

This block lets software reach the management registers of external Ethernet PHYs over a two-wire serial management bus. Software writes one 32-bit access word. The word holds a request flag, a direction flag, a 5-bit PHY address, a 5-bit register address and a 16-bit data field. The controller then sends a full management frame on MDC/MDIO. When the frame ends, the controller clears the request flag. For a read, it also places the returned register value in the low half of the word.

The request flag has two roles. Setting it starts a transaction. Reading it back tells software whether that transaction is still running. Software polls bit 31 until it reads 0, then picks up the result from the same word. MDC is made from the system clock by a parameterised divider. MDC runs only while a frame is in progress and stays low otherwise.

Top module: `mdio_access_ctrl`

## Requirements
- R1: A write with bit 31 set while idle starts a transaction: from the next cycle, busy is 1 and bit 31 of reg_rdata reads 1.
- R2: A transaction lasts exactly 64 MDC periods, which is 128*DIV_HALF system cycles. After that, busy drops and bit 31 reads 0.
- R3: A write access (bit 30 = 1) sends 64 bits, MSB first. The bits are 32 ones, then 01, then 01, then the PHY address from bits [25:21], then the register address from bits [20:16], then 10, then the data from bits [15:0]. mdio_oe is high for all 64 bits.
- R4: A read access (bit 30 = 0) sends the same preamble, then 01, then 10, then both addresses. mdio_oe is low from the first turnaround bit (frame bit 46) to the end of the frame.
- R5: During a read, mdio_i is sampled at each MDC rising edge of frame bits 48..63, MSB first. At completion the value appears in reg_rdata[15:0], and bits [30:16] still hold the direction and addresses.
- R6: While busy, MDC has a period of 2*DIV_HALF system cycles and a high time of DIV_HALF cycles. mdio_o and mdio_oe change only while MDC is low.
- R7: Writes to the access word while busy have no effect on the running frame or on the word.
- R8: A write with bit 31 clear while idle only loads the fields, with no frame and no MDC activity. Bits [29:26] always read 0.
- R9: After reset, reg_rdata is 0 and busy, mdc and mdio_oe are 0. When idle, mdc and mdio_oe stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the access word |
| reg_wdata | input | 32 | Access word write value |
| reg_rdata | output | 32 | Current access word (request, direction, addresses, data) |
| busy | output | 1 | High while a frame is in progress |
| mdc | output | 1 | Management clock |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_o | output | 1 | MDIO output value |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench builds the controller with DIV_HALF = 2, so a full frame takes 256 system cycles. At that length, several complete writes and reads, with their cycle-exact durations, fit in a short run. A half period of two cycles also makes an MDC high phase span more than one clock edge. That lets the bench catch an MDIO change while MDC is high, and measure the high time against the parameter. The PHY model answers reads with distinct data patterns, so a bit-order or sampling-edge error shows up in the returned value.

// File: rtl/mdio_access_ctrl.sv
module mdio_access_ctrl #(
  parameter int DIV_HALF = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        busy,
  output logic        mdc,
  output logic        mdio_oe,
  output logic        mdio_o,
  input  logic        mdio_i
);
  localparam int FRAME_BITS = 64;
  localparam int TA_FIRST   = 46;
  localparam int DATA_FIRST = 48;
  localparam int CW  = $clog2(DIV_HALF + 1);
  localparam int IW  = $clog2(FRAME_BITS);
  localparam int LEN = FRAME_BITS * 2 * DIV_HALF;
  localparam int LW  = $clog2(LEN + 1) + 1;

  logic                  req, wr_op, mdc_q;
  logic [4:0]            phy, regad;
  logic [15:0]           data;
  logic [CW-1:0]         div_cnt;
  logic [IW-1:0]         bit_idx;
  logic [FRAME_BITS-1:0] sh;
  logic                  tick, start;

  assign tick  = req && (div_cnt == CW'(DIV_HALF - 1));
  assign start = reg_wr && !req && reg_wdata[31];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req <= 1'b0; wr_op <= 1'b0; mdc_q <= 1'b0;
      phy <= '0; regad <= '0; data <= '0;
      div_cnt <= '0; bit_idx <= '0; sh <= '0;
    end else if (reg_wr && !req) begin
      req     <= reg_wdata[31];
      wr_op   <= reg_wdata[30];
      phy     <= reg_wdata[25:21];
      regad   <= reg_wdata[20:16];
      data    <= reg_wdata[15:0];
      div_cnt <= '0;
      mdc_q   <= 1'b0;
      bit_idx <= '0;
      sh      <= {32'hFFFF_FFFF, 2'b01, reg_wdata[30] ? 2'b01 : 2'b10,
                  reg_wdata[25:21], reg_wdata[20:16], 2'b10, reg_wdata[15:0]};
    end else if (req) begin
      div_cnt <= tick ? '0 : div_cnt + CW'(1);
      if (tick) begin
        if (!mdc_q) begin
          mdc_q <= 1'b1;
          if (!wr_op && bit_idx >= IW'(DATA_FIRST))
            data <= {data[14:0], mdio_i};
        end else begin
          mdc_q <= 1'b0;
          if (bit_idx == IW'(FRAME_BITS - 1)) begin
            req <= 1'b0;
          end else begin
            bit_idx <= bit_idx + IW'(1);
            sh      <= {sh[FRAME_BITS-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign busy      = req;
  assign mdc       = mdc_q;
  assign mdio_oe   = req && (wr_op || bit_idx < IW'(TA_FIRST));
  assign mdio_o    = mdio_oe & sh[FRAME_BITS-1];
  assign reg_rdata = {req, wr_op, 4'b0000, phy, regad, data};

  logic [LW-1:0] chk_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     chk_cnt <= '0;
    else if (start) chk_cnt <= '0;
    else if (req)   chk_cnt <= chk_cnt + LW'(1);
  end

  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && reg_rdata[31]));

  p_frame_length_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (chk_cnt == LW'(LEN)));

  p_stable_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

  p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr) |=> $stable(reg_rdata[30:16]));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));
endmodule

// File: tb/mdio_access_ctrl_bench.sv
`timescale 1ns/100ps
module mdio_access_ctrl_bench;
  localparam int HALF = 2;
  localparam int NVEC = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        busy, mdc, mdio_oe, mdio_o;
  logic        mdio_i = 1'b1;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  mdio_access_ctrl #(.DIV_HALF(HALF)) u_mdio_access_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .busy(busy), .mdc(mdc), .mdio_oe(mdio_oe),
    .mdio_o(mdio_o), .mdio_i(mdio_i));

  always #2.5 clk = ~clk;

  // {access word, PHY response, expected final readback}
  localparam logic [79:0] VEC [NVEC] = '{
    {32'hC0A0_9000, 16'h0000, 32'h40A0_9000},
    {32'hC0C0_9000, 16'h0000, 32'h40C0_9000},
    {32'h80C1_0000, 16'h786D, 32'h00C1_786D},
    {32'h83FF_0000, 16'hA5A5, 32'h03FF_A5A5},
    {32'hC000_0000, 16'hFFFF, 32'h4000_0000},
    {32'hBC21_5555, 16'h0001, 32'h0021_0001}
  };

  logic        rec_o  [64];
  logic        rec_oe [64];
  int          mon_idx = 0;
  logic [15:0] resp = '0;

  always @(posedge mdc) begin
    if (mon_idx < 64) begin
      rec_o[mon_idx]  = mdio_o;
      rec_oe[mon_idx] = mdio_oe;
    end
    mon_idx++;
  end

  always @(negedge mdc) begin
    if (mon_idx >= 48 && mon_idx < 64) mdio_i = resp[63 - mon_idx];
    else mdio_i = 1'b1;
  end

  int   high_run = 0;
  int   period_err = 0;
  int   glitch_err = 0;
  logic prev_mdc = 1'b0;
  logic prev_o = 1'b0;
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mdc && prev_mdc && (mdio_o !== prev_o || mdio_oe !== prev_oe)) glitch_err++;
      if (mdc) high_run++;
      if (!mdc && prev_mdc) begin
        if (high_run != HALF) period_err++;
        high_run = 0;
      end
    end
    prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input logic [31:0] w);
    return {32'hFFFF_FFFF, 2'b01, w[30] ? 2'b01 : 2'b10, w[25:21], w[20:16], 2'b10, w[15:0]};
  endfunction

  task automatic run(input logic [31:0] word, input logic [15:0] rv,
                     input logic [31:0] exp_rb, input bit inject);
    logic [63:0] ef;
    int cycles;
    int bad_o;
    int bad_oe;
    resp = rv;
    mon_idx = 0;
    @(negedge clk); reg_wr = 1'b1; reg_wdata = word;
    @(negedge clk); reg_wr = 1'b0;
    chk(busy === 1'b1 && reg_rdata[31] === 1'b1, "R1 start", {31'b0, busy, reg_rdata}, 64'h1_8000_0000);
    cycles = 0;
    while (busy === 1'b1 && cycles < 10000) begin
      cycles++;
      if (inject && cycles == 40) begin reg_wr = 1'b1; reg_wdata = 32'hC3FF_FFFF; end
      else reg_wr = 1'b0;
      @(negedge clk);
    end
    reg_wr = 1'b0;
    chk(cycles == 128 * HALF, "R2 duration", cycles, 128 * HALF);
    chk(reg_rdata === exp_rb, word[30] ? "R2 readback" : "R5 read data", reg_rdata, exp_rb);
    chk(mon_idx == 64, "R2 mdc periods", mon_idx, 64);
    ef = exp_frame(word);
    bad_o = 0; bad_oe = 0;
    for (int i = 0; i < 64; i++) begin
      if (word[30] || i < 46) begin
        if (rec_o[i] !== ef[63 - i]) bad_o++;
        if (rec_oe[i] !== 1'b1) bad_oe++;
      end else if (rec_oe[i] !== 1'b0) bad_oe++;
    end
    chk(bad_o == 0, word[30] ? "R3 frame bits" : "R4 frame bits", bad_o, 0);
    chk(bad_oe == 0, word[30] ? "R3 output enable" : "R4 turnaround release", bad_oe, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(reg_rdata === 32'h0 && busy === 1'b0 && mdc === 1'b0 && mdio_oe === 1'b0,
        "R9 reset state", {busy, mdc, mdio_oe, reg_rdata}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && mdc === 1'b0 && mdio_oe === 1'b0, "R9 idle after reset",
        {busy, mdc, mdio_oe}, 0);

    for (int v = 0; v < NVEC; v++) begin
      logic [79:0] e;
      e = VEC[v];
      run(e[79:48], e[47:32], e[31:0], 1'b0);
      repeat (5) @(negedge clk);
    end

    // R7: write during a read frame is ignored
    run(32'h80C1_0000, 16'h1234, 32'h00C1_1234, 1'b1);
    repeat (5) @(negedge clk);

    // R8: idle write without request loads fields only
    mon_idx = 0;
    @(negedge clk); reg_wr = 1'b1; reg_wdata = 32'h3FFF_FFFF;
    @(negedge clk); reg_wr = 1'b0;
    chk(reg_rdata === 32'h03FF_FFFF, "R8 field load", reg_rdata, 32'h03FF_FFFF);
    repeat (20) @(negedge clk);
    chk(busy === 1'b0 && mon_idx == 0 && mdio_oe === 1'b0, "R8 no frame",
        {busy, mdio_oe, 32'(mon_idx)}, 0);

    chk(period_err == 0, "R6 mdc high time", period_err, 0);
    chk(glitch_err == 0, "R6 mdio change while mdc high", glitch_err, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule